// File: doc/BRIEF.md
# Word-Serial Large-Integer Multiplier with Sum/Carry Output

This block multiplies two n-bit unsigned integers over several clock cycles. Operand A is split into 17-bit words, and each word feeds its own multiply element. Operand B is consumed as 24-bit digits, one digit per cycle, starting with the least significant. In each cycle every element forms the 41-bit product of its A word and the current B digit. The element splits that product into a 17-bit low part and a 24-bit high part. These parts are then folded into a running accumulator that is kept in carry-save form, so no long carry chain is ever resolved.

After each digit the accumulator gives up its lowest 24 bits: the sum part is written into one result vector and the carry part into the other. The accumulator then shifts down by one digit, which converts the 17-bit word positions into 24-bit digit positions. A final flush cycle writes what remains of the accumulator into the upper bits of both vectors. The product leaves as two vectors, a sum vector and a carry vector, whose ordinary sum equals A*B. A downstream adder or reducer finishes the carry resolution.

A one-cycle `start_i` loads both operands. `done_o` pulses once when the result is valid. The result then holds until the next accepted start.

Top module: `wsmul_core`

## Requirements
- R1: The sum rr_o + rc_o, taken modulo 2^(2n), equals a_i*b_i as sampled on the start edge, for any operands.
- R2: The multiplication takes D = ceil(n/24) digit cycles plus one flush cycle. Counting the edge that samples start_i as edge 1, done_o is high after edge D+2 and low again after the next edge.
- R3: start_i, a_i and b_i are ignored from the edge that accepts a start until done_o is asserted. A second start in that window produces no extra result and does not change the pending one.
- R4: After reset, done_o is 0 and rr_o and rc_o are all zero.
- R5: The extreme operands give exact products: both operands all-ones (maximum carries in every element), one operand zero, and a single set bit in the top position.
- R6: While idle with start_i low, rr_o and rc_o hold their values whatever a_i and b_i do.
- R7: At the flush cycle, the accumulator's sum and carry parts each fit in the 2n - 24*D upper result bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a multiplication (honoured only when idle) |
| a_i | input | OP_W | Multiplicand A, WORD_W*N_WORDS bits |
| b_i | input | OP_W | Multiplier B, consumed as 24-bit digits |
| rr_o | output | 2*OP_W | Sum half of the redundant product |
| rc_o | output | 2*OP_W | Carry half of the redundant product |
| done_o | output | 1 | One-cycle pulse when rr_o/rc_o are valid |

## Verification
The in-line properties watch the control rules on every cycle. They check that done_o is a single-cycle pulse, that the digit counter stays in range, that the results hold while idle and that captured operands stay frozen while busy. They also check that the leftover accumulator fits the upper result field at flush. The arithmetic claim, that the two vectors really add up to the product, can only be shown by the bench scenarios. Those scenarios include random operands, all-ones operands with maximal carries, zero and single-bit operands, a second start during a run, and operand changes while idle, all compared against a wide reference product.

// File: rtl/wsmul_pkg.sv
package wsmul_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN   = 2'd1,
        PH_FLUSH = 2'd2
    } phase_e;
endpackage

// File: rtl/wsmul_csa.sv
// 3:2 carry-save compressor over a full accumulator width.
module wsmul_csa #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);
    logic [W-1:0] maj;

    always_comb begin
        s_o = x_i ^ y_i ^ z_i;
        maj = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
        c_o = {maj[W-2:0], 1'b0};
    end
endmodule

// File: rtl/wsmul_mac_row.sv
// Row of multiply elements: every A word times the current B digit.
// Each element splits its product into a word-wide low part and a
// digit-wide high part.
module wsmul_mac_row #(
    parameter int WORD_W  = 17,
    parameter int N_WORDS = 4,
    parameter int DIG_W   = 24
) (
    input  logic [WORD_W*N_WORDS-1:0] a_i,
    input  logic [DIG_W-1:0]          dig_i,
    output logic [WORD_W*N_WORDS-1:0] lo_o,
    output logic [DIG_W*N_WORDS-1:0]  hi_o
);
    localparam int PROD_W = WORD_W + DIG_W;

    for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_elem
        logic [PROD_W-1:0] prod;

        always_comb begin
            prod = PROD_W'(a_i[gi*WORD_W +: WORD_W]) * PROD_W'(dig_i);
        end

        assign lo_o[gi*WORD_W +: WORD_W] = prod[WORD_W-1:0];
        assign hi_o[gi*DIG_W +: DIG_W]   = prod[PROD_W-1:WORD_W];
    end
endmodule

// File: rtl/wsmul_core.sv
module wsmul_core
    import wsmul_pkg::*;
#(
    parameter int WORD_W  = 17,
    parameter int N_WORDS = 4,
    parameter int DIG_W   = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [WORD_W*N_WORDS-1:0]     a_i,
    input  logic [WORD_W*N_WORDS-1:0]     b_i,
    output logic [2*WORD_W*N_WORDS-1:0]   rr_o,
    output logic [2*WORD_W*N_WORDS-1:0]   rc_o,
    output logic                          done_o
);
    localparam int OP_W  = WORD_W * N_WORDS;
    localparam int ND    = (OP_W + DIG_W - 1) / DIG_W;
    localparam int BP_W  = ND * DIG_W;
    localparam int PW    = 2 * OP_W;
    localparam int LOW_W = ND * DIG_W;
    localparam int HI_W  = PW - LOW_W;
    localparam int AW    = OP_W + DIG_W + 2;
    localparam int CNT_W = (ND > 1) ? $clog2(ND) : 1;

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [OP_W-1:0]   a;
        logic [BP_W-1:0]   b;
        logic [AW-1:0]     s;
        logic [AW-1:0]     c;
        logic [PW-1:0]     rr;
        logic [PW-1:0]     rc;
        logic              done;
    } state_t;

    state_t st_d, st_q;

    // multiply row on the current digit
    logic [OP_W-1:0]       row_lo;
    logic [DIG_W*N_WORDS-1:0] row_hi;

    wsmul_mac_row #(
        .WORD_W (WORD_W),
        .N_WORDS(N_WORDS),
        .DIG_W  (DIG_W)
    ) u_row (
        .a_i  (st_q.a),
        .dig_i(st_q.b[DIG_W-1:0]),
        .lo_o (row_lo),
        .hi_o (row_hi)
    );

    // high parts overlap neighbours, so even and odd elements go in separate vectors
    logic [AW-1:0] pp_lo, pp_hev, pp_hod;

    always_comb begin
        pp_lo  = AW'(row_lo);
        pp_hev = '0;
        pp_hod = '0;
        for (int i = 0; i < N_WORDS; i++) begin
            if ((i % 2) == 0)
                pp_hev[WORD_W*(i+1) +: DIG_W] = row_hi[i*DIG_W +: DIG_W];
            else
                pp_hod[WORD_W*(i+1) +: DIG_W] = row_hi[i*DIG_W +: DIG_W];
        end
    end

    // five operands folded by three compressor levels
    logic [AW-1:0] l1_s, l1_c, l2_s, l2_c, l3_s, l3_c;

    wsmul_csa #(.W(AW)) u_csa1 (
        .x_i(st_q.s), .y_i(st_q.c), .z_i(pp_lo),  .s_o(l1_s), .c_o(l1_c));
    wsmul_csa #(.W(AW)) u_csa2 (
        .x_i(l1_s),   .y_i(l1_c),   .z_i(pp_hev), .s_o(l2_s), .c_o(l2_c));
    wsmul_csa #(.W(AW)) u_csa3 (
        .x_i(l2_s),   .y_i(l2_c),   .z_i(pp_hod), .s_o(l3_s), .c_o(l3_c));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.a   = a_i;
                    st_d.b   = BP_W'(b_i);
                    st_d.s   = '0;
                    st_d.c   = '0;
                    st_d.cnt = '0;
                    st_d.rr  = '0;
                    st_d.rc  = '0;
                    st_d.ph  = PH_RUN;
                end
            end
            PH_RUN: begin
                st_d.rr[int'(st_q.cnt)*DIG_W +: DIG_W] = l3_s[DIG_W-1:0];
                st_d.rc[int'(st_q.cnt)*DIG_W +: DIG_W] = l3_c[DIG_W-1:0];
                st_d.s   = l3_s >> DIG_W;
                st_d.c   = l3_c >> DIG_W;
                st_d.b   = st_q.b >> DIG_W;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_W'(ND - 1))
                    st_d.ph = PH_FLUSH;
            end
            PH_FLUSH: begin
                st_d.rr[PW-1:LOW_W] = st_q.s[HI_W-1:0];
                st_d.rc[PW-1:LOW_W] = st_q.c[HI_W-1:0];
                st_d.done = 1'b1;
                st_d.ph   = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rr_o   = st_q.rr;
    assign rc_o   = st_q.rc;
    assign done_o = st_q.done;

    // R2: the completion flag never lasts two cycles
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: the digit counter never passes the last digit while running
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUN) |-> (int'(st_q.cnt) < ND));

    // R3: captured operands stay frozen while a run is in progress
    p_busy_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUN && st_d.ph == PH_RUN) |=> $stable(st_q.a));

    // R6: results hold while idle without a start
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE && !start_i) |=> ($stable(rr_o) && $stable(rc_o)));

    // R7: leftover sum and carry fit the upper result field
    p_upper_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_FLUSH) |-> ((st_q.s >> HI_W) == '0 && (st_q.c >> HI_W) == '0));
endmodule

// File: tb/wsmul_core_tb.sv
module wsmul_core_tb;
    localparam int WORD_W  = 17;
    localparam int N_WORDS = 4;
    localparam int DIG_W   = 24;
    localparam int OP_W    = WORD_W * N_WORDS;
    localparam int PW      = 2 * OP_W;
    localparam int ND      = (OP_W + DIG_W - 1) / DIG_W;
    localparam int LAT     = ND + 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [OP_W-1:0] a_i = '0;
    logic [OP_W-1:0] b_i = '0;
    logic [PW-1:0]   rr_o, rc_o;
    logic            done_o;

    wsmul_core #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .DIG_W(DIG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
        .rr_o(rr_o), .rc_o(rc_o), .done_o(done_o));

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int dones = 0;
    int issued = 0;
    logic [PW-1:0] exp_q[$];
    int            t_q[$];
    logic [PW-1:0] last_prod = '0;
    bit            finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every completion
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            dones++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected completion", PW'(dones), PW'(issued));
            end else begin
                logic [PW-1:0] e;
                int            t;
                e = exp_q.pop_front();
                t = t_q.pop_front();
                chk((rr_o + rc_o) == e, "R1 product", rr_o + rc_o, e);
                chk((cyc - t) == LAT, "R2 latency", PW'(cyc - t), PW'(LAT));
                last_prod = e;
            end
        end
    end

    task automatic wait_done(input int target);
        while (dones < target) @(negedge clk);
    endtask

    // driver: pushes the expected product and pulses start
    task automatic run_op(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                          input bit poke_busy);
        @(negedge clk);
        a_i = a; b_i = b; start_i = 1'b1;
        exp_q.push_back(PW'(a) * PW'(b));
        t_q.push_back(cyc);
        issued++;
        @(negedge clk);
        start_i = 1'b0;
        if (poke_busy) begin
            // R3: second start while busy must be ignored
            a_i = ~a; b_i = b ^ OP_W'(32'h5a5a_1234); start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_done(issued);
    endtask

    function automatic logic [OP_W-1:0] rnd();
        return OP_W'({$urandom(), $urandom(), $urandom()});
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R4: reset state
        chk(done_o == 1'b0, "R4 done low", PW'(done_o), '0);
        chk(rr_o == '0, "R4 rr zero", rr_o, '0);
        chk(rc_o == '0, "R4 rc zero", rc_o, '0);
        rst_n = 1'b1;

        // R1: distinct patterns
        run_op(OP_W'(68'h0_0001_2345_6789_ABCD), OP_W'(68'h0_0000_0000_0000_0003), 1'b0);
        run_op(OP_W'(68'hF_0F0F_0F0F_0F0F_0F0F), OP_W'(68'hA_AAAA_AAAA_AAAA_AAAA), 1'b0);
        for (int k = 0; k < 10; k++) run_op(rnd(), rnd(), 1'b0);

        // R5: corners
        run_op('1, '1, 1'b0);
        run_op('0, rnd(), 1'b0);
        run_op(rnd(), '0, 1'b0);
        run_op(OP_W'(1) << (OP_W-1), OP_W'(1) << (OP_W-1), 1'b0);
        run_op('1, OP_W'(1), 1'b0);

        // R3: start while busy
        run_op(rnd(), rnd(), 1'b1);
        repeat (LAT + 3) @(negedge clk);
        chk(dones == issued, "R3 no extra completion", PW'(dones), PW'(issued));

        // R6: operand changes while idle leave results untouched
        a_i = rnd(); b_i = rnd();
        repeat (6) @(negedge clk);
        a_i = '1; b_i = '1;
        repeat (4) @(negedge clk);
        chk((rr_o + rc_o) == last_prod, "R6 hold while idle", rr_o + rc_o, last_prod);

        chk(exp_q.size() == 0, "R1 scoreboard drained", PW'(exp_q.size()), '0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule